// File: doc/BRIEF.md
# DMA Channel Request Gating and Grant Scheduler

This block decides, every clock cycle, which DMA channel may move one data element. For each channel it reads the channel's configuration word and its remaining element count, then combines them with the peripheral request lines. Requests arrive on two 32-bit vectors, one for single transfers and one for bursts, and the block ORs them into one request vector. From these inputs it works out which channels are eligible. A registered arbiter then issues at most one grant. The datapath that performs the transfer sits next to this block and uses the one-hot grant or the grant index.

Each configuration word carries a 3-bit flow type. The flow type selects which peripheral requests must be present before the channel may move data: none, only the destination's, only the source's, or both. Flow types 4 to 7 hand flow control to a peripheral. That case is not supported here, so for such a channel the block raises a per-channel error flag and issues no grant. The arbiter keeps a grant on one channel for as long as that channel stays eligible. When the channel stops being eligible, the arbiter moves on to the next eligible channel above it, wrapping around to the lowest index.

Top module: `dmafc_gate`

## Requirements
- R1: A channel can be granted only when its configuration bit 0 (enable) is 1 and its bit 18 (halt) is 0.
- R2: Bits 13:11 of the configuration word hold the flow type, bits 5:1 hold the source peripheral number and bits 10:6 hold the destination peripheral number. Each peripheral number selects one bit of the request vector.
- R3: The request vector used for gating is the bitwise OR of `req_single` and `req_burst`. A request on either input satisfies the channel.
- R4: Flow type 0 needs no request. Type 1 needs the destination peripheral's request. Type 2 needs the source peripheral's request. Type 3 needs both requests.
- R5: A channel whose remaining count is zero is never eligible.
- R6: A granted channel keeps the grant, with an unchanged index, in every following cycle in which it is still eligible and the global enable is 1.
- R7: If the granted channel is no longer eligible, or no grant is held, the next grant goes to the first eligible channel found by scanning upward from the index after the last granted one, wrapping to index 0. After reset the scan starts at index 0. Whenever any channel is eligible and the global enable is 1, a grant is issued.
- R8: An enabled, non-halted channel with flow type 4 to 7 sets its bit in `unsup_err` and is never granted.
- R9: While `glb_en` is 0, the next cycle shows no grant and no error flags.
- R10: At most one bit of `grant_oh` is set. `grant_vld` is 1 exactly when a bit is set, and that bit is the one at `grant_idx`. Outputs change on the clock edge after the inputs that cause them.
- R11: While reset is asserted, `grant_oh`, `grant_vld` and `unsup_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global enable for granting |
| ch_cfg | input | NUM_CH*32 | Per-channel configuration words, channel 0 in the low bits |
| ch_cnt | input | NUM_CH*CNT_W | Per-channel remaining element counts |
| req_single | input | 32 | Single-transfer request lines, one per peripheral |
| req_burst | input | 32 | Burst request lines, one per peripheral |
| grant_oh | output | NUM_CH | Registered one-hot grant |
| grant_vld | output | 1 | A grant is held |
| grant_idx | output | IDX_W | Index of the granted channel, or of the last granted one |
| unsup_err | output | NUM_CH | Registered per-channel unsupported-flow-type flags |

## Verification
The first sweep configures one channel at a time. It steps that channel through every flow type and every enable and halt combination, with zero, small and full counts. For each combination it tries every presence pattern of the source and destination requests, delivered on the single input in some runs and on the burst input in others. Unrelated request lines carry noise, so a wrong field position or a wrong request bit leads to a wrong grant. A second phase runs several channels at once, changing one channel per cycle and toggling the global enable now and then. The grant index is compared against a reference of the hold-then-rotate rule, which separates holding the grant from rescanning the channels, from wrapping past the top index, and from a fixed lowest-index priority. Directed steps after a fresh reset confirm that the scan starts at index 0.

// File: rtl/dmafc_pkg.sv
package dmafc_pkg;

  localparam int CFG_W     = 32;
  localparam int PERIPH_W  = 5;
  localparam int REQ_W     = 1 << PERIPH_W;
  localparam int FLOW_W    = 3;

  // bit positions inside a channel configuration word
  localparam int EN_BIT    = 0;
  localparam int SRC_LSB   = 1;
  localparam int DST_LSB   = 6;
  localparam int FLOW_LSB  = 11;
  localparam int HALT_BIT  = 18;

  // supported flow types
  localparam logic [FLOW_W-1:0] FLOW_MEM_MEM   = 3'd0;
  localparam logic [FLOW_W-1:0] FLOW_MEM_PER   = 3'd1;
  localparam logic [FLOW_W-1:0] FLOW_PER_MEM   = 3'd2;
  localparam logic [FLOW_W-1:0] FLOW_PER_PER   = 3'd3;

  typedef struct packed {
    logic                enable;
    logic                halt;
    logic [FLOW_W-1:0]   flow;
    logic [PERIPH_W-1:0] src_per;
    logic [PERIPH_W-1:0] dst_per;
  } chan_fields_t;

  function automatic chan_fields_t decode_cfg(input logic [CFG_W-1:0] cfg);
    chan_fields_t f;
    f.enable  = cfg[EN_BIT];
    f.halt    = cfg[HALT_BIT];
    f.flow    = cfg[FLOW_LSB +: FLOW_W];
    f.src_per = cfg[SRC_LSB +: PERIPH_W];
    f.dst_per = cfg[DST_LSB +: PERIPH_W];
    return f;
  endfunction

endpackage

// File: rtl/dmafc_chan_eval.sv
module dmafc_chan_eval
  import dmafc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic [REQ_W-1:0] req_eff,
  output logic             eligible,
  output logic             unsupported
);

  chan_fields_t fld;
  logic         active;
  logic         src_req;
  logic         dst_req;
  logic         flow_ok;
  logic         cnt_nz;

  always_comb begin
    fld     = decode_cfg(cfg);
    active  = fld.enable && !fld.halt;
    src_req = req_eff[fld.src_per];
    dst_req = req_eff[fld.dst_per];
    cnt_nz  = |cnt;
    unique case (fld.flow)
      FLOW_MEM_MEM: flow_ok = 1'b1;
      FLOW_MEM_PER: flow_ok = dst_req;
      FLOW_PER_MEM: flow_ok = src_req;
      FLOW_PER_PER: flow_ok = src_req && dst_req;
      default:      flow_ok = 1'b0;
    endcase
    unsupported = active && fld.flow[FLOW_W-1];
    eligible    = active && cnt_nz && flow_ok;
  end

  // R5: an empty count never produces an eligible channel
  always_comb begin
    if (cnt == '0) begin
      p_zero_count_r5: assert (!eligible);
    end
  end

endmodule

// File: rtl/dmafc_rr_pick.sv
module dmafc_rr_pick #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] cand,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              pick_vld,
  output logic [IDX_W-1:0]  pick_idx
);

  int pos;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = last_idx;
    pos      = 0;
    for (int k = 1; k <= NUM_CH; k++) begin
      pos = (int'(last_idx) + k) % NUM_CH;
      if (!pick_vld && cand[pos]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(pos);
      end
    end
  end

  // R7: the scan finds a channel whenever any candidate exists
  always_comb begin
    p_pick_any_r7: assert (pick_vld == (|cand));
  end

endmodule

// File: rtl/dmafc_gate.sv
module dmafc_gate
  import dmafc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 12,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic [NUM_CH*CNT_W-1:0] ch_cnt,
  input  logic [REQ_W-1:0]        req_single,
  input  logic [REQ_W-1:0]        req_burst,
  output logic [NUM_CH-1:0]       grant_oh,
  output logic                    grant_vld,
  output logic [IDX_W-1:0]        grant_idx,
  output logic [NUM_CH-1:0]       unsup_err
);

  logic [REQ_W-1:0]  req_eff;
  logic [NUM_CH-1:0] elig_vec;
  logic [NUM_CH-1:0] unsup_vec;
  logic              pick_vld;
  logic [IDX_W-1:0]  pick_idx;

  logic              grant_vld_q, grant_vld_d;
  logic [IDX_W-1:0]  grant_idx_q;
  logic              idx_en;
  logic              hold;
  logic [NUM_CH-1:0] err_q, err_d;

  assign req_eff = req_single | req_burst;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dmafc_chan_eval #(.CNT_W(CNT_W)) i_eval (
      .cfg         (ch_cfg[c*CFG_W +: CFG_W]),
      .cnt         (ch_cnt[c*CNT_W +: CNT_W]),
      .req_eff     (req_eff),
      .eligible    (elig_vec[c]),
      .unsupported (unsup_vec[c])
    );
  end

  dmafc_rr_pick #(.NUM_CH(NUM_CH)) i_pick (
    .cand     (elig_vec),
    .last_idx (grant_idx_q),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  // next state
  always_comb begin
    hold        = grant_vld_q && elig_vec[grant_idx_q];
    grant_vld_d = glb_en && (hold || pick_vld);
    idx_en      = glb_en && !hold && pick_vld;
    err_d       = glb_en ? unsup_vec : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_vld_q <= 1'b0;
      grant_idx_q <= IDX_W'(NUM_CH - 1);
      err_q       <= '0;
    end else begin
      grant_vld_q <= grant_vld_d;
      if (idx_en) begin
        grant_idx_q <= pick_idx;
      end
      err_q <= err_d;
    end
  end

  always_comb begin
    grant_oh = '0;
    if (grant_vld_q) begin
      grant_oh[grant_idx_q] = 1'b1;
    end
  end

  assign grant_vld = grant_vld_q;
  assign grant_idx = grant_idx_q;
  assign unsup_err = err_q;

  // R8: a channel flagged as unsupported never holds the grant
  p_no_grant_unsup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> !unsup_err[grant_idx]);

  // R9: global disable clears grant and error flags next cycle
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (!grant_vld && (unsup_err == '0)));

  // R6: an eligible holder keeps the grant
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && glb_en && elig_vec[grant_idx]) |=> (grant_vld && $stable(grant_idx)));

  // R7: some grant follows whenever any channel is eligible
  p_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && (|elig_vec)) |=> grant_vld);

  // R10: grant vector and valid agree
  p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ($countones(grant_oh) == 1));

endmodule

// File: tb/test_dmafc_gate.sv
module test_dmafc_gate;

  localparam int NCH   = 4;
  localparam int CNT_W = 12;
  localparam int IDX_W = 2;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  glb_en;
  logic [NCH*32-1:0]     ch_cfg;
  logic [NCH*CNT_W-1:0]  ch_cnt;
  logic [31:0]           req_single, req_burst;
  logic [NCH-1:0]        grant_oh;
  logic                  grant_vld;
  logic [IDX_W-1:0]      grant_idx;
  logic [NCH-1:0]        unsup_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  // reference scheduler state
  logic           m_vld;
  int             m_idx;

  always #2 clk = ~clk;

  dmafc_gate #(.NUM_CH(NCH), .CNT_W(CNT_W)) i_dmafc_gate (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_cfg(ch_cfg), .ch_cnt(ch_cnt),
    .req_single(req_single), .req_burst(req_burst), .grant_oh(grant_oh),
    .grant_vld(grant_vld), .grant_idx(grant_idx), .unsup_err(unsup_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] mkcfg(input logic en, input logic halt, input logic [2:0] flow,
                                        input logic [4:0] src, input logic [4:0] dst);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[18] = halt; w[13:11] = flow; w[5:1] = src; w[10:6] = dst;
    return w;
  endfunction

  // eligibility straight from R1 to R5
  function automatic logic ref_elig(input logic [31:0] cfg, input logic [CNT_W-1:0] cnt,
                                    input logic [31:0] req);
    logic ok;
    case (cfg[13:11])
      3'd0: ok = 1'b1;
      3'd1: ok = req[cfg[10:6]];
      3'd2: ok = req[cfg[5:1]];
      3'd3: ok = req[cfg[5:1]] && req[cfg[10:6]];
      default: ok = 1'b0;
    endcase
    return cfg[0] && !cfg[18] && (cnt != 0) && ok;
  endfunction

  function automatic logic ref_unsup(input logic [31:0] cfg);
    return cfg[0] && !cfg[18] && cfg[13];
  endfunction

  // advance the reference one edge, then compare at the next negedge
  task automatic step_and_check(input string tag);
    logic [NCH-1:0] e, u;
    logic [31:0]    rq;
    logic [NCH-1:0] exp_oh;
    rq = req_single | req_burst;
    for (int c = 0; c < NCH; c++) begin
      e[c] = ref_elig(ch_cfg[c*32 +: 32], ch_cnt[c*CNT_W +: CNT_W], rq);
      u[c] = ref_unsup(ch_cfg[c*32 +: 32]);
    end
    if (!glb_en) begin
      m_vld = 1'b0;
    end else if (m_vld && e[m_idx]) begin
      m_vld = 1'b1;
    end else begin
      m_vld = 1'b0;
      for (int k = 1; k <= NCH; k++) begin
        if (!m_vld && e[(m_idx + k) % NCH]) begin
          m_vld = 1'b1;
          m_idx = (m_idx + k) % NCH;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    exp_oh = m_vld ? NCH'(1 << m_idx) : '0;
    chk({tag, " R10 grant_oh"}, 64'(grant_oh), 64'(exp_oh));
    chk({tag, " R10 grant_vld"}, 64'(grant_vld), 64'(m_vld));
    if (m_vld) chk({tag, " R7 grant_idx"}, 64'(grant_idx), 64'(m_idx));
    chk({tag, " R8 unsup_err"}, 64'(unsup_err), 64'(glb_en ? u : '0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_vld = 1'b0;
    m_idx = NCH - 1;
    repeat (2) @(negedge clk);
    chk("R11 reset grant_oh", 64'(grant_oh), 64'd0);
    chk("R11 reset grant_vld", 64'(grant_vld), 64'd0);
    chk("R11 reset unsup_err", 64'(unsup_err), 64'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    glb_en = 1'b1; ch_cfg = '0; ch_cnt = '0; req_single = '0; req_burst = '0;
    do_reset();

    // single-channel sweep: R1 R2 R3 R4 R5 R8
    for (int fl = 0; fl < 8; fl++)
      for (int en = 0; en < 2; en++)
        for (int ht = 0; ht < 2; ht++)
          for (int cs = 0; cs < 3; cs++)
            for (int rp = 0; rp < 8; rp++) begin
              logic [4:0] s, d;
              logic [31:0] r, noise;
              rng = next_rng(rng);
              s = rng[4:0];
              d = rng[9:5];
              noise = next_rng(rng) & ~(32'd1 << s) & ~(32'd1 << d);
              r = noise;
              if (rp[0]) r = r | (32'd1 << s);
              if (rp[1]) r = r | (32'd1 << d);
              ch_cfg = '0;
              ch_cfg[31:0] = mkcfg(en[0], ht[0], fl[2:0], s, d);
              ch_cnt = '0;
              ch_cnt[CNT_W-1:0] = (cs == 0) ? 12'd0 : (cs == 1) ? 12'd1 : 12'hFFF;
              if (rp[2]) begin req_single = '0; req_burst = r; end
              else begin req_single = r; req_burst = '0; end
              step_and_check("R1 R2 R3 R4 R5 sweep");
            end

    // R9: global disable blocks grants and error flags
    ch_cfg = '0;
    ch_cfg[31:0]  = mkcfg(1'b1, 1'b0, 3'd0, 5'd0, 5'd0);
    ch_cfg[63:32] = mkcfg(1'b1, 1'b0, 3'd6, 5'd0, 5'd0);
    ch_cnt = {NCH{12'd5}};
    glb_en = 1'b0;
    step_and_check("R9 disabled");
    step_and_check("R9 disabled hold");
    glb_en = 1'b1;
    step_and_check("R9 reenabled");

    // directed ordering after a fresh reset: R7 then R6
    ch_cfg = '0; ch_cnt = '0;
    do_reset();
    ch_cfg[31:0]  = mkcfg(1'b1, 1'b0, 3'd0, 5'd0, 5'd0);
    ch_cfg[95:64] = mkcfg(1'b1, 1'b0, 3'd0, 5'd0, 5'd0);
    ch_cnt = {NCH{12'd3}};
    step_and_check("R7 scan from 0");
    chk("R7 first grant index 0", 64'(grant_idx), 64'd0);
    step_and_check("R6 hold");
    step_and_check("R6 hold");
    chk("R6 holder unchanged", 64'(grant_idx), 64'd0);
    ch_cnt[CNT_W-1:0] = '0;
    step_and_check("R7 move on");
    chk("R7 next eligible above", 64'(grant_idx), 64'd2);
    ch_cnt[CNT_W-1:0] = 12'd3;
    ch_cfg[63:32] = mkcfg(1'b1, 1'b0, 3'd0, 5'd0, 5'd0);
    ch_cfg[95:64] = '0;
    step_and_check("R7 wrap");
    chk("R7 wrap to lowest", 64'(grant_idx), 64'd0);

    // multi-channel scheduling against reference: R6 R7 R8 R9 R10
    for (int t = 0; t < 3000; t++) begin
      int c;
      logic [2:0] fl;
      rng = next_rng(rng);
      c = int'(rng[1:0]);
      fl = (rng[2] & rng[3] & rng[4]) ? rng[7:5] : {1'b0, rng[6:5]};
      ch_cfg[c*32 +: 32] = mkcfg(rng[8] | rng[9], rng[10] & rng[11] & rng[12], fl,
                                 rng[17:13], rng[22:18]);
      ch_cnt[c*CNT_W +: CNT_W] = (rng[25:23] == 0) ? 12'd0 : {rng[31:26], rng[5:0]} | 12'd1;
      rng = next_rng(rng);
      req_single = rng & next_rng(rng);
      req_burst  = next_rng(rng) & next_rng(next_rng(rng));
      glb_en = (rng[7:4] != 4'd0);
      step_and_check("R6 R7 schedule");
    end

    finish_run();
  end

endmodule